// File: doc/BRIEF.md
# Indexed Gather Load Sequencer

This block carries out one indexed (gather) vector load. A start pulse supplies a scalar base address, the active vector length, the element width (SEW), the memory access width, signedness, the number of segment fields and an all-active flag. The block steps through the elements in order. For each active element it reads the offset from the index vector port, extends it according to signedness and adds it to the base.

Work runs in two passes. The first pass sends one probe request per active element, covering every byte that the element's segment fields will touch. Data reads start only when every probe has come back clean. The second pass reads each field, extends the returned value to SEW and writes it into a destination slot. The block then writes zero into the tail slots of every field.

A probe fault ends the operation at once with an error flag and the faulting element number. In that case no destination slot is written. The memory port keeps at most one request in flight.

Top module: `gather_load_seq`

## Requirements
- R1: The element address is base plus the index element read at SEW width, where the size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The index is sign-extended when `cfg_signed` is 1 and zero-extended when it is 0. Index bits above SEW are ignored.
- R2: When `cfg_all_active` is 0 and `mask_value` is 0 for an element, that element gets no probe, no read and no destination write. A mask bit of 1 marks an element as active.
- R3: A start with `cfg_vl` equal to 0 raises `done` one cycle later. `busy` stays low, and the block issues no memory request and no write.
- R4: Each active element gets one probe (`mem_probe`=1), in ascending element order, at the element address. The probe length `mem_len` is (`cfg_nf_m1`+1) times the access width in bytes. No data read (`mem_probe`=0) is issued until every probe has completed without a fault.
- R5: Field k of element i is read at the element address plus k times the access width. It is written to slot i + k*vlmax, where vlmax = VLEN_BYTES >> SEW code.
- R6: Returned data is sign-extended (signed) or zero-extended (unsigned) from the access width to SEW. `wr_data` bits above SEW are zero.
- R7: After the reads, slots vl to vlmax-1 of every field are written with zero.
- R8: A probe answered with `mem_rsp_fault` ends the operation. `done` and `error` are raised, `err_elem` holds the element number, and no further request and no destination write follow.
- R9: `mem_req` is a one-cycle pulse, and no new request is issued until the previous one has been answered.
- R10: `busy` is high from the cycle after start until the cycle in which the one-cycle `done` pulse appears. `error` is cleared by the next start.
- R11: After reset, `busy`, `done`, `error`, `mem_req` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| cfg_base | input | W | Scalar base address |
| cfg_vl | input | EW | Active vector length |
| cfg_sew | input | 2 | Element width code (0/1/2 = 1/2/4 bytes) |
| cfg_msz | input | 2 | Memory access width code, not above `cfg_sew` |
| cfg_signed | input | 1 | 1 selects sign extension of index and data |
| cfg_nf_m1 | input | NFW | Segment field count minus one |
| cfg_all_active | input | 1 | 1 ignores the mask |
| rd_elem | output | EW | Element number for the index and mask read ports |
| idx_value | input | W | Index element at `rd_elem` |
| mask_value | input | 1 | Mask bit at `rd_elem` |
| mem_req | output | 1 | Memory request pulse |
| mem_probe | output | 1 | 1 = probe request, 0 = data read |
| mem_addr | output | W | Request byte address |
| mem_len | output | LW | Request length in bytes |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | W | Read data, little-endian |
| mem_rsp_fault | input | 1 | Probe fault, valid with the response |
| wr_en | output | 1 | Destination slot write |
| wr_slot | output | SW | Destination slot number |
| wr_data | output | W | Destination slot value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last operation ended on a probe fault |
| err_elem | output | EW | Faulting element number |

## Verification
Every output is registered. A response seen at a clock edge therefore shows up as a slot write in the following cycle, and a start is answered one edge later by either `busy` or, for zero length, `done`. The bench drives all inputs and samples all outputs on the falling edge. A monitor logs every request and write in the cycle it appears. Each scenario waits for `done`, lets one extra falling edge pass, then compares the logged slots, request addresses and counts against values computed from the requirements. The `done` pulse width and the flags are checked on the falling edges just after start and just after completion.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [2:0] {
    GS_IDLE,
    GS_PROBE_CHK,
    GS_PROBE_WAIT,
    GS_LOAD_CHK,
    GS_LOAD_ISSUE,
    GS_LOAD_WAIT,
    GS_TAIL
  } gather_state_e;
endpackage

// File: rtl/gather_ext.sv
module gather_ext #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [1:0]   size,
  input  logic         sgn,
  output logic [W-1:0] res
);
  localparam int IW = $clog2(W);

  logic [IW-1:0] top_bit;

  always_comb begin
    case (size)
      2'd0:    top_bit = IW'(7);
      2'd1:    top_bit = IW'(15);
      default: top_bit = IW'(W - 1);
    endcase
  end

  always_comb begin
    res = val;
    for (int j = 0; j < W; j++) begin
      if (j > int'(top_bit)) res[j] = sgn & val[top_bit];
    end
  end
endmodule

// File: rtl/gather_addr.sv
module gather_addr #(
  parameter int W          = 32,
  parameter int VLEN_BYTES = 16,
  parameter int EW         = 5,
  parameter int NFW        = 2,
  parameter int SW         = 6,
  parameter int LW         = 5
) (
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   idx_ext,
  input  logic [EW-1:0]  elem,
  input  logic [NFW-1:0] field,
  input  logic [NFW-1:0] nf_m1,
  input  logic [1:0]     sew,
  input  logic [1:0]     msz,
  output logic [W-1:0]   addr,
  output logic [SW-1:0]  slot,
  output logic [EW-1:0]  vlmax,
  output logic [LW-1:0]  seg_len
);
  localparam int VSH = $clog2(VLEN_BYTES);

  assign addr    = base + idx_ext + (W'(field) << msz);
  assign vlmax   = EW'(VLEN_BYTES >> sew);
  assign slot    = SW'(elem) + (SW'(field) << (VSH - int'(sew)));
  assign seg_len = LW'((int'(nf_m1) + 1) << msz);
endmodule

// File: rtl/gather_fsm.sv
module gather_fsm
  import gather_pkg::*;
#(
  parameter int W   = 32,
  parameter int EW  = 5,
  parameter int NFW = 2,
  parameter int SW  = 6,
  parameter int LW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   cfg_base,
  input  logic [EW-1:0]  cfg_vl,
  input  logic [1:0]     cfg_sew,
  input  logic [1:0]     cfg_msz,
  input  logic           cfg_signed,
  input  logic [NFW-1:0] cfg_nf_m1,
  input  logic           cfg_all_active,
  input  logic           mask_value,
  input  logic           mem_rsp_valid,
  input  logic           mem_rsp_fault,
  input  logic [W-1:0]   addr_in,
  input  logic [SW-1:0]  slot_in,
  input  logic [EW-1:0]  vlmax_in,
  input  logic [LW-1:0]  len_in,
  input  logic [W-1:0]   data_in,
  output logic [EW-1:0]  cur_elem,
  output logic [NFW-1:0] cur_field,
  output logic [W-1:0]   base_q,
  output logic [1:0]     sew_q,
  output logic [1:0]     msz_q,
  output logic           sgn_q,
  output logic [NFW-1:0] nf_q,
  output logic           mem_req,
  output logic           mem_probe,
  output logic [W-1:0]   mem_addr,
  output logic [LW-1:0]  mem_len,
  output logic           wr_en,
  output logic [SW-1:0]  wr_slot,
  output logic [W-1:0]   wr_data,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic [EW-1:0]  err_elem
);
  gather_state_e st;
  logic [EW-1:0] vl_q;
  logic          vm_q;
  logic          active;

  assign active = vm_q | mask_value;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= GS_IDLE;
      cur_elem  <= '0;
      cur_field <= '0;
      base_q    <= '0;
      sew_q     <= '0;
      msz_q     <= '0;
      sgn_q     <= 1'b0;
      nf_q      <= '0;
      vl_q      <= '0;
      vm_q      <= 1'b0;
      mem_req   <= 1'b0;
      mem_probe <= 1'b0;
      mem_addr  <= '0;
      mem_len   <= '0;
      wr_en     <= 1'b0;
      wr_slot   <= '0;
      wr_data   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      err_elem  <= '0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      wr_en   <= 1'b0;
      case (st)
        GS_IDLE: if (start) begin
          base_q    <= cfg_base;
          vl_q      <= cfg_vl;
          sew_q     <= cfg_sew;
          msz_q     <= cfg_msz;
          sgn_q     <= cfg_signed;
          nf_q      <= cfg_nf_m1;
          vm_q      <= cfg_all_active;
          error     <= 1'b0;
          cur_elem  <= '0;
          cur_field <= '0;
          if (cfg_vl == '0) begin
            done <= 1'b1;
          end else begin
            busy <= 1'b1;
            st   <= GS_PROBE_CHK;
          end
        end
        GS_PROBE_CHK: begin
          if (cur_elem == vl_q) begin
            cur_elem <= '0;
            st       <= GS_LOAD_CHK;
          end else if (active) begin
            mem_req   <= 1'b1;
            mem_probe <= 1'b1;
            mem_addr  <= addr_in;
            mem_len   <= len_in;
            st        <= GS_PROBE_WAIT;
          end else begin
            cur_elem <= cur_elem + 1'b1;
          end
        end
        GS_PROBE_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_fault) begin
            error    <= 1'b1;
            err_elem <= cur_elem;
            busy     <= 1'b0;
            done     <= 1'b1;
            st       <= GS_IDLE;
          end else begin
            cur_elem <= cur_elem + 1'b1;
            st       <= GS_PROBE_CHK;
          end
        end
        GS_LOAD_CHK: begin
          if (cur_elem == vl_q) begin
            cur_field <= '0;
            st        <= GS_TAIL;
          end else if (active) begin
            cur_field <= '0;
            st        <= GS_LOAD_ISSUE;
          end else begin
            cur_elem <= cur_elem + 1'b1;
          end
        end
        GS_LOAD_ISSUE: begin
          mem_req   <= 1'b1;
          mem_probe <= 1'b0;
          mem_addr  <= addr_in;
          mem_len   <= LW'(1) << msz_q;
          st        <= GS_LOAD_WAIT;
        end
        GS_LOAD_WAIT: if (mem_rsp_valid) begin
          wr_en   <= 1'b1;
          wr_slot <= slot_in;
          wr_data <= data_in;
          if (cur_field == nf_q) begin
            cur_elem <= cur_elem + 1'b1;
            st       <= GS_LOAD_CHK;
          end else begin
            cur_field <= cur_field + 1'b1;
            st        <= GS_LOAD_ISSUE;
          end
        end
        GS_TAIL: begin
          if (cur_elem == vlmax_in) begin
            if (cur_field == nf_q) begin
              busy <= 1'b0;
              done <= 1'b1;
              st   <= GS_IDLE;
            end else begin
              cur_field <= cur_field + 1'b1;
              cur_elem  <= vl_q;
            end
          end else begin
            wr_en    <= 1'b1;
            wr_slot  <= slot_in;
            wr_data  <= '0;
            cur_elem <= cur_elem + 1'b1;
          end
        end
        default: st <= GS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gather_load_seq.sv
module gather_load_seq #(
  parameter int W          = 32,
  parameter int VLEN_BYTES = 16,
  parameter int MAX_NF     = 4,
  localparam int EW  = $clog2(VLEN_BYTES + 1),
  localparam int NFW = (MAX_NF > 1) ? $clog2(MAX_NF) : 1,
  localparam int SW  = $clog2(MAX_NF * VLEN_BYTES),
  localparam int LW  = $clog2(MAX_NF * (W / 8) + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   cfg_base,
  input  logic [EW-1:0]  cfg_vl,
  input  logic [1:0]     cfg_sew,
  input  logic [1:0]     cfg_msz,
  input  logic           cfg_signed,
  input  logic [NFW-1:0] cfg_nf_m1,
  input  logic           cfg_all_active,
  output logic [EW-1:0]  rd_elem,
  input  logic [W-1:0]   idx_value,
  input  logic           mask_value,
  output logic           mem_req,
  output logic           mem_probe,
  output logic [W-1:0]   mem_addr,
  output logic [LW-1:0]  mem_len,
  input  logic           mem_rsp_valid,
  input  logic [W-1:0]   mem_rsp_data,
  input  logic           mem_rsp_fault,
  output logic           wr_en,
  output logic [SW-1:0]  wr_slot,
  output logic [W-1:0]   wr_data,
  output logic           busy,
  output logic           done,
  output logic           error,
  output logic [EW-1:0]  err_elem
);
  logic [EW-1:0]  cur_elem;
  logic [NFW-1:0] cur_field;
  logic [W-1:0]   base_q;
  logic [1:0]     sew_q;
  logic [1:0]     msz_q;
  logic           sgn_q;
  logic [NFW-1:0] nf_q;
  logic [W-1:0]   idx_ext;
  logic [W-1:0]   dat_ext;
  logic [W-1:0]   dat_sew;
  logic [W-1:0]   elem_addr;
  logic [SW-1:0]  slot;
  logic [EW-1:0]  vlmax;
  logic [LW-1:0]  seg_len;

  assign rd_elem = cur_elem;

  gather_ext #(.W(W)) u_idx_ext (
    .val(idx_value), .size(sew_q), .sgn(sgn_q), .res(idx_ext)
  );

  gather_ext #(.W(W)) u_dat_ext (
    .val(mem_rsp_data), .size(msz_q), .sgn(sgn_q), .res(dat_ext)
  );

  always_comb begin
    for (int b = 0; b < W / 8; b++) begin
      dat_sew[b*8 +: 8] = (b < int'(32'd1 << sew_q)) ? dat_ext[b*8 +: 8] : 8'h00;
    end
  end

  gather_addr #(
    .W(W), .VLEN_BYTES(VLEN_BYTES), .EW(EW), .NFW(NFW), .SW(SW), .LW(LW)
  ) u_addr (
    .base(base_q), .idx_ext(idx_ext), .elem(cur_elem), .field(cur_field),
    .nf_m1(nf_q), .sew(sew_q), .msz(msz_q), .addr(elem_addr), .slot(slot),
    .vlmax(vlmax), .seg_len(seg_len)
  );

  gather_fsm #(.W(W), .EW(EW), .NFW(NFW), .SW(SW), .LW(LW)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_vl(cfg_vl),
    .cfg_sew(cfg_sew), .cfg_msz(cfg_msz), .cfg_signed(cfg_signed),
    .cfg_nf_m1(cfg_nf_m1), .cfg_all_active(cfg_all_active),
    .mask_value(mask_value), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_fault(mem_rsp_fault), .addr_in(elem_addr), .slot_in(slot),
    .vlmax_in(vlmax), .len_in(seg_len), .data_in(dat_sew),
    .cur_elem(cur_elem), .cur_field(cur_field), .base_q(base_q),
    .sew_q(sew_q), .msz_q(msz_q), .sgn_q(sgn_q), .nf_q(nf_q),
    .mem_req(mem_req), .mem_probe(mem_probe), .mem_addr(mem_addr),
    .mem_len(mem_len), .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .busy(busy), .done(done), .error(error), .err_elem(err_elem)
  );
endmodule

// File: rtl/gather_load_seq_chk.sv
module gather_load_seq_chk #(
  parameter int EW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [EW-1:0] cfg_vl,
  input logic          mem_req,
  input logic          mem_probe,
  input logic          mem_rsp_valid,
  input logic          wr_en,
  input logic          busy,
  input logic          done,
  input logic          error
);
  logic outst;
  logic rd_seen;
  logic wrote;

  always_ff @(posedge clk) begin
    if (rst) begin
      outst   <= 1'b0;
      rd_seen <= 1'b0;
      wrote   <= 1'b0;
    end else begin
      if (mem_req) outst <= 1'b1;
      else if (mem_rsp_valid) outst <= 1'b0;
      if (start && !busy) rd_seen <= 1'b0;
      else if (mem_req && !mem_probe) rd_seen <= 1'b1;
      if (start && !busy) wrote <= 1'b0;
      else if (wr_en) wrote <= 1'b1;
    end
  end

  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !outst);
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  a_r4_probes_first: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_probe) |-> !rd_seen);
  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && error) |-> !wrote);
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r10_write_while_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);
  a_r3_zero_length: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg_vl == '0) |=> (done && !busy && !mem_req));
endmodule

bind gather_load_seq gather_load_seq_chk #(.EW(EW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cfg_vl(cfg_vl), .mem_req(mem_req),
  .mem_probe(mem_probe), .mem_rsp_valid(mem_rsp_valid), .wr_en(wr_en),
  .busy(busy), .done(done), .error(error)
);

// File: tb/sim_gather_load_seq.sv
`timescale 1ns/1ps
module sim_gather_load_seq;
  localparam int W = 32, VLB = 16, MNF = 4;
  localparam int EW = 5, NFW = 2, SW = 6, LW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic           start = 1'b0;
  logic [W-1:0]   cfg_base = '0;
  logic [EW-1:0]  cfg_vl = '0;
  logic [1:0]     cfg_sew = '0, cfg_msz = '0;
  logic           cfg_signed = 1'b0, cfg_all_active = 1'b1;
  logic [NFW-1:0] cfg_nf_m1 = '0;
  logic [EW-1:0]  rd_elem;
  logic [W-1:0]   idx_value;
  logic           mask_value;
  logic           mem_req, mem_probe;
  logic [W-1:0]   mem_addr;
  logic [LW-1:0]  mem_len;
  logic           rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [W-1:0]   rsp_data = '0;
  logic           wr_en;
  logic [SW-1:0]  wr_slot;
  logic [W-1:0]   wr_data;
  logic           busy, done, error;
  logic [EW-1:0]  err_elem;

  logic [31:0] idx_mem [0:31];
  logic        mask_mem [0:31];
  logic [7:0]  mem [0:255];
  logic [31:0] dest [0:63];

  assign idx_value  = idx_mem[rd_elem];
  assign mask_value = mask_mem[rd_elem];

  gather_load_seq #(.W(W), .VLEN_BYTES(VLB), .MAX_NF(MNF)) u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_base(cfg_base), .cfg_vl(cfg_vl),
    .cfg_sew(cfg_sew), .cfg_msz(cfg_msz), .cfg_signed(cfg_signed),
    .cfg_nf_m1(cfg_nf_m1), .cfg_all_active(cfg_all_active), .rd_elem(rd_elem),
    .idx_value(idx_value), .mask_value(mask_value), .mem_req(mem_req),
    .mem_probe(mem_probe), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data),
    .mem_rsp_fault(rsp_fault), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(wr_data), .busy(busy), .done(done), .error(error),
    .err_elem(err_elem)
  );

  int checks = 0, errors = 0, cycles = 0;
  int req_count, probe_count, read_count, wr_count, order_bad, overlap;
  logic [31:0] req_addr [0:127];
  logic [7:0]  req_len [0:127];
  logic        fault_en = 1'b0;
  logic [31:0] fault_at = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[8'(a)]};
  endfunction

  function automatic logic [31:0] xt(input logic [31:0] v, input int from_b,
                                     input int to_b, input logic sgn);
    logic [31:0] fm, tm, r;
    fm = (from_b >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (from_b * 8)) - 1);
    tm = (to_b >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (to_b * 8)) - 1);
    r = v & fm;
    if (sgn && v[from_b * 8 - 1]) r = r | ~fm;
    return r & tm;
  endfunction

  // Memory responder: answers one cycle after it sees a request.
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (mem_req) begin
        req_addr[req_count[6:0]] = mem_addr;
        req_len[req_count[6:0]]  = 8'(mem_len);
        req_count++;
        if (mem_probe) begin
          probe_count++;
          if (read_count != 0) order_bad++;
        end else read_count++;
        @(negedge clk);
        if (mem_req) overlap++;
        rsp_valid = 1'b1;
        rsp_data  = mem_probe ? 32'h0 : rd_mem(mem_addr);
        rsp_fault = mem_probe && fault_en && (fault_at >= mem_addr) &&
                    (fault_at < mem_addr + 32'(mem_len));
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (wr_en) begin
        dest[wr_slot] = wr_data;
        wr_count++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic prep();
    for (int i = 0; i < 64; i++) dest[i] = 32'hDEAD_BEEF;
    for (int i = 0; i < 32; i++) mask_mem[i] = 1'b1;
    req_count = 0; probe_count = 0; read_count = 0; wr_count = 0;
    order_bad = 0; overlap = 0; fault_en = 1'b0;
  endtask

  task automatic run(input logic [31:0] base, input int vl, input int sew,
                     input int msz, input logic sgn, input int nfm1,
                     input logic vm, output int cyc);
    @(negedge clk);
    cfg_base = base; cfg_vl = EW'(vl); cfg_sew = 2'(sew); cfg_msz = 2'(msz);
    cfg_signed = sgn; cfg_nf_m1 = NFW'(nfm1); cfg_all_active = vm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (vl != 0) check("R10 busy after start", busy, 1);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    @(negedge clk);
    check("R10 done is a pulse", done, 0);
    check("R10 busy low after done", busy, 0);
    check("R9 one request in flight", overlap, 0);
    check("R4 probes before reads", order_bad, 0);
  endtask

  task automatic t_reset();
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 error", error, 0);
    check("R11 mem_req", mem_req, 0);
    check("R11 wr_en", wr_en, 0);
  endtask

  task automatic t_basic();
    int c;
    prep();
    idx_mem[0] = 8; idx_mem[1] = 0; idx_mem[2] = 20; idx_mem[3] = 4;
    run(32'h40, 4, 2, 2, 1'b1, 0, 1'b1, c);
    for (int i = 0; i < 4; i++)
      check("R5 word slot", dest[i], rd_mem(32'h40 + idx_mem[i]));
    check("R4 probe count", probe_count, 4);
    check("R4 probe len", req_len[0], 4);
    check("R1 first address", req_addr[0], 32'h48);
    check("R5 read count", read_count, 4);
    check("R7 no tail when vl=vlmax", wr_count, 4);
    check("R10 no error", error, 0);
  endtask

  task automatic t_halfword(input logic sgn);
    int c;
    prep();
    mem[8'h7C] = 8'h80; mem[8'h82] = 8'h7F; mem[8'h90] = 8'hFF;
    idx_mem[0] = 32'hABCD_FFFC; idx_mem[1] = 32'h1234_0002; idx_mem[2] = 32'h0000_0010;
    run(32'h80, 3, 1, 0, sgn, 0, 1'b1, c);
    check("R1 index at SEW width", req_addr[0], sgn ? 32'h7C : 32'h1007C);
    check("R6 ext slot0", dest[0], sgn ? 32'hFF80 : 32'h0080);
    check("R6 ext slot1", dest[1], 32'h007F);
    check("R6 ext slot2", dest[2], sgn ? 32'hFFFF : 32'h00FF);
    for (int i = 3; i < 8; i++) check("R7 tail zero", dest[i], 0);
    check("R7 write count", wr_count, 8);
  endtask

  task automatic t_mask();
    int c;
    prep();
    for (int i = 0; i < 4; i++) idx_mem[i] = 32'(i * 6 + 2);
    mask_mem[0] = 1; mask_mem[1] = 0; mask_mem[2] = 0; mask_mem[3] = 1;
    run(32'h20, 4, 2, 1, 1'b1, 0, 1'b0, c);
    check("R2 probe count", probe_count, 2);
    check("R2 read count", read_count, 2);
    check("R2 skipped slot1", dest[1], 32'hDEAD_BEEF);
    check("R2 skipped slot2", dest[2], 32'hDEAD_BEEF);
    check("R6 active slot0", dest[0], xt(rd_mem(32'h22), 2, 4, 1'b1));
    check("R6 active slot3", dest[3], xt(rd_mem(32'h34), 2, 4, 1'b1));
  endtask

  task automatic t_segment();
    int c;
    prep();
    idx_mem[0] = 32'h10; idx_mem[1] = 32'h20;
    run(32'h0, 2, 0, 0, 1'b0, 2, 1'b1, c);
    check("R4 segment probe len", req_len[0], 3);
    check("R5 field address", req_addr[7], 32'h22);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 2; i++)
        check("R5 segment slot", dest[i + k * 16], 32'(mem[8'(idx_mem[i] + 32'(k))]));
      for (int i = 2; i < 16; i++)
        check("R7 segment tail", dest[i + k * 16], 0);
    end
    check("R7 segment writes", wr_count, 48);
  endtask

  task automatic t_zero_len();
    int c;
    prep();
    run(32'h0, 0, 2, 2, 1'b0, 0, 1'b1, c);
    check("R3 done next cycle", c, 1);
    check("R3 no request", req_count, 0);
    check("R3 no write", wr_count, 0);
  endtask

  task automatic t_fault();
    int c;
    prep();
    for (int i = 0; i < 4; i++) idx_mem[i] = 32'(i * 4);
    fault_en = 1'b1; fault_at = 32'h49;
    run(32'h40, 4, 2, 2, 1'b0, 0, 1'b1, c);
    check("R8 error", error, 1);
    check("R8 err_elem", err_elem, 2);
    check("R8 probes stop", probe_count, 3);
    check("R8 no read", read_count, 0);
    check("R8 no write", wr_count, 0);
    check("R8 dest unchanged", dest[0], 32'hDEAD_BEEF);
    prep();
    run(32'h40, 1, 2, 2, 1'b0, 0, 1'b1, c);
    check("R10 error cleared", error, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    for (int i = 0; i < 32; i++) idx_mem[i] = '0;
    prep();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_halfword(1'b1);
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    t_halfword(1'b0);
    t_mask();
    t_segment();
    t_zero_len();
    t_fault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule